// File: doc/BRIEF.md
# Indirect Command-Register Bus Bridge

This block lets a 64-bit register port, as found on a scan-style configuration path, reach a device space that is only reachable through a narrow internal bus. The internal bus has a 32-bit address and an 8-bit data path. Software first loads a data word. It then writes one command word that holds the direction, a byte count and a target address. It then polls a status word. When the transfer is finished, the status word holds a completion flag and, for reads, the gathered bytes. Reading the status word also clears it.

Inside, a small state machine performs the internal-bus transfer as one byte beat per valid/ready handshake. It waits for each byte response before it issues the next beat. The states are IDLE, ISSUE and AWAIT. A legal command moves IDLE to ISSUE ("launch"). An accepted beat moves ISSUE to AWAIT ("accept"). A response that is neither the last beat nor an error moves AWAIT back to ISSUE ("next beat"). The last response, or an error response, moves AWAIT to IDLE ("finish"). A command with an illegal byte count stays in IDLE and completes in the same cycle ("reject").

Top module: `cmdreg_bridge`

## Requirements
- R1: The register slot is the port offset modulo 4. Slot 0 is command, slot 1 is reset, slot 2 is status and slot 3 is data. The command and reset slots always read zero. A write to the reset slot changes no register and starts no transfer.
- R2: A write to the data slot keeps bits 63:32 of the written value. A read of the data slot returns that word in bits 63:32 and zero in bits 31:0.
- R3: A command-slot write starts a transfer. In the command word, bit 48 = 1 means read and 0 means write. Bits 59:56 give the byte count N, and bits 31:0 give the base address. Beat i (0..N-1) targets base+i, wrapping modulo 2^32, and carries N in its size field.
- R4: Write beat i carries bits [31-8i -: 8] of the data word held at launch, so the most significant byte goes first. A finished write sets status to bit 11 only.
- R5: A finished read sets status to bit 11 plus a 32-bit field in bits 57:26. Byte i of the response sits at field bits [31-8i -: 8], and field bytes that were not fetched are zero.
- R6: A beat whose response carries the error flag ends the transfer; no later beat is issued. For a read, the status field becomes all ones, next to bit 11. For a write, the status is bit 11 only.
- R7: A status read returns the held value and clears it to zero. Writes to the status slot are ignored.
- R8: While a transfer is outstanding, command writes are ignored and status reads return zero without clearing.
- R9: A byte count of 0 or above 4 issues no beat and completes at once. A read then gives bit 11 plus an all-ones field, and a write gives bit 11 only.
- R10: A beat request holds its valid, address, direction and write byte unchanged until it is accepted.
- R11: After reset, all slots read zero and no request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_rd_en | input | 1 | Register port read strobe |
| reg_addr | input | REG_ADDR_W | Register offset (decoded modulo 4) |
| reg_wdata | input | 64 | Register write value |
| reg_rdata | output | 64 | Register read value, valid while reg_rd_en is high |
| bus_req_valid | output | 1 | Beat request valid |
| bus_req_ready | input | 1 | Beat request accepted |
| bus_req_write | output | 1 | Beat direction, 1 = write |
| bus_req_addr | output | BUS_ADDR_W | Beat byte address |
| bus_req_size | output | 4 | Total byte count of the transfer |
| bus_req_wdata | output | 8 | Write byte |
| bus_rsp_valid | input | 1 | Beat response valid |
| bus_rsp_rdata | input | 8 | Read byte |
| bus_rsp_err | input | 1 | Beat error flag |

## Verification
The hardest situation to reach from the ports is a command write, or a status read, that lands while a transfer is still pending. Normal polling finishes before software can issue the next command. The bench therefore holds the bus model's ready low, so the machine stays in ISSUE. While it is held, the bench sends a second command and a status read, and only then releases the bus. An error on a middle beat is also hard to reach: the bus model flags one chosen address, and the bench checks that the beat count stops there.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    localparam int REG_W         = 64;
    localparam int BYTE_W        = 8;
    localparam int SIZE_W        = 4;
    localparam int MAX_BYTES     = 4;
    localparam int WORD_W        = BYTE_W * MAX_BYTES;
    localparam int CTL_READ_BIT  = 48;
    localparam int CTL_SIZE_LSB  = 56;
    localparam int STAT_DONE_BIT = 11;
    localparam int STAT_DATA_LSB = 26;

    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_RESET  = 2'd1,
        SLOT_STATUS = 2'd2,
        SLOT_DATA   = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } eng_state_e;
endpackage

// File: rtl/cmdreg_engine.sv
module cmdreg_engine
    import cmdreg_pkg::*;
#(
    parameter int BUS_ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch,
    input  logic                  cmd_read,
    input  logic [SIZE_W-1:0]     cmd_size,
    input  logic [BUS_ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0]     cmd_word,
    output logic                  busy,
    output logic                  bus_req_valid,
    input  logic                  bus_req_ready,
    output logic                  bus_req_write,
    output logic [BUS_ADDR_W-1:0] bus_req_addr,
    output logic [SIZE_W-1:0]     bus_req_size,
    output logic [BYTE_W-1:0]     bus_req_wdata,
    input  logic                  bus_rsp_valid,
    input  logic [BYTE_W-1:0]     bus_rsp_rdata,
    input  logic                  bus_rsp_err,
    output logic                  cpl_valid,
    output logic                  cpl_write,
    output logic                  cpl_err,
    output logic [WORD_W-1:0]     cpl_data
);
    eng_state_e              state_q, state_d;
    logic [BUS_ADDR_W-1:0]   base_q;
    logic [SIZE_W-1:0]       size_q;
    logic [SIZE_W-1:0]       cnt_q;
    logic                    read_q;
    logic [WORD_W-1:0]       wshift_q;
    logic [WORD_W-1:0]       acc_q;
    logic [WORD_W-1:0]       acc_merge;
    logic                    size_ok;
    logic                    last_beat;

    assign size_ok   = (cmd_size != '0) && (cmd_size <= SIZE_W'(MAX_BYTES));
    assign last_beat = (cnt_q == size_q - SIZE_W'(1));

    always_comb begin
        acc_merge = acc_q | (WORD_W'(bus_rsp_rdata)
                    << (WORD_W - BYTE_W * (int'(cnt_q) + 1)));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch && size_ok) state_d = ST_ISSUE;
            ST_ISSUE: if (bus_req_ready) state_d = ST_AWAIT;
            ST_AWAIT: if (bus_rsp_valid)
                          state_d = (bus_rsp_err || last_beat) ? ST_IDLE : ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // transfer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            size_q   <= '0;
            cnt_q    <= '0;
            read_q   <= 1'b0;
            wshift_q <= '0;
            acc_q    <= '0;
        end else if (state_q == ST_IDLE) begin
            if (launch && size_ok) begin
                base_q   <= cmd_addr;
                size_q   <= cmd_size;
                cnt_q    <= '0;
                read_q   <= cmd_read;
                wshift_q <= cmd_word;
                acc_q    <= '0;
            end
        end else if (state_q == ST_AWAIT && bus_rsp_valid) begin
            cnt_q    <= cnt_q + SIZE_W'(1);
            acc_q    <= acc_merge;
            wshift_q <= wshift_q << BYTE_W;
        end
    end

    // outputs
    always_comb begin
        bus_req_valid = 1'b0;
        cpl_valid     = 1'b0;
        cpl_write     = 1'b0;
        cpl_err       = 1'b0;
        cpl_data      = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (launch && !size_ok) begin
                    cpl_valid = 1'b1;
                    cpl_err   = 1'b1;
                    cpl_write = !cmd_read;
                end
            end
            ST_ISSUE: bus_req_valid = 1'b1;
            ST_AWAIT: begin
                if (bus_rsp_valid && (bus_rsp_err || last_beat)) begin
                    cpl_valid = 1'b1;
                    cpl_err   = bus_rsp_err;
                    cpl_write = !read_q;
                    cpl_data  = acc_merge;
                end
            end
            default: ;
        endcase
    end

    assign busy          = (state_q != ST_IDLE);
    assign bus_req_write = !read_q;
    assign bus_req_addr  = base_q + BUS_ADDR_W'(cnt_q);
    assign bus_req_size  = size_q;
    assign bus_req_wdata = wshift_q[WORD_W-1 -: BYTE_W];

    // R10: a pending request stays unchanged until accepted
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=>
            (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata)
             && $stable(bus_req_write)));

    // R9: only legal byte counts reach the bus
    a_r9_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_size != '0 && bus_req_size <= SIZE_W'(MAX_BYTES)));

    // R6: an error response ends the transfer
    a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsp_valid && bus_rsp_err && busy) |=> !bus_req_valid);
endmodule

// File: rtl/cmdreg_regs.sv
module cmdreg_regs
    import cmdreg_pkg::*;
#(
    parameter int REG_ADDR_W = 4,
    parameter int BUS_ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  busy,
    input  logic                  cpl_valid,
    input  logic                  cpl_write,
    input  logic                  cpl_err,
    input  logic [WORD_W-1:0]     cpl_data,
    output logic                  launch,
    output logic                  cmd_read,
    output logic [SIZE_W-1:0]     cmd_size,
    output logic [BUS_ADDR_W-1:0] cmd_addr,
    output logic [WORD_W-1:0]     cmd_word
);
    slot_e              slot;
    logic [WORD_W-1:0]  data_q;
    logic [REG_W-1:0]   stat_q;
    logic [REG_W-1:0]   stat_new;
    logic               stat_rd;
    logic               unused_addr_bits;

    assign slot             = slot_e'(reg_addr[1:0]);
    assign unused_addr_bits = ^reg_addr;
    assign stat_rd          = reg_rd_en && (slot == SLOT_STATUS) && !busy;

    assign launch   = reg_wr_en && (slot == SLOT_CTRL) && !busy;
    assign cmd_read = reg_wdata[CTL_READ_BIT];
    assign cmd_size = reg_wdata[CTL_SIZE_LSB +: SIZE_W];
    assign cmd_addr = reg_wdata[BUS_ADDR_W-1:0];
    assign cmd_word = data_q;

    always_comb begin
        stat_new = '0;
        stat_new[STAT_DONE_BIT] = 1'b1;
        if (!cpl_write)
            stat_new[STAT_DATA_LSB +: WORD_W] = cpl_err ? '1 : cpl_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            stat_q <= '0;
        end else begin
            if (reg_wr_en && slot == SLOT_DATA)
                data_q <= reg_wdata[REG_W-1 -: WORD_W];
            if (cpl_valid)
                stat_q <= stat_new;
            else if (stat_rd)
                stat_q <= '0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en) begin
            unique case (slot)
                SLOT_STATUS: reg_rdata = busy ? '0 : stat_q;
                SLOT_DATA:   reg_rdata = {data_q, {(REG_W-WORD_W){1'b0}}};
                default:     reg_rdata = '0;
            endcase
        end
    end

    // R7: a status read clears the value it returned
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !cpl_valid) |=> (stat_q == '0));

    // R7: writes to the status slot leave it alone
    a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && slot == SLOT_STATUS && !cpl_valid && !stat_rd) |=> $stable(stat_q));

    // R8: status reads during a transfer show zero
    a_r8_busy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && slot == SLOT_STATUS && busy) |-> (reg_rdata == '0));

    // R1: command and reset slots read zero
    a_r1_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && (slot == SLOT_CTRL || slot == SLOT_RESET)) |-> (reg_rdata == '0));
endmodule

// File: rtl/cmdreg_bridge.sv
module cmdreg_bridge
    import cmdreg_pkg::*;
#(
    parameter int REG_ADDR_W = 4,
    parameter int BUS_ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_en,
    input  logic                  reg_rd_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [63:0]           reg_wdata,
    output logic [63:0]           reg_rdata,
    output logic                  bus_req_valid,
    input  logic                  bus_req_ready,
    output logic                  bus_req_write,
    output logic [BUS_ADDR_W-1:0] bus_req_addr,
    output logic [3:0]            bus_req_size,
    output logic [7:0]            bus_req_wdata,
    input  logic                  bus_rsp_valid,
    input  logic [7:0]            bus_rsp_rdata,
    input  logic                  bus_rsp_err
);
    logic                  busy;
    logic                  launch;
    logic                  cmd_read;
    logic [SIZE_W-1:0]     cmd_size;
    logic [BUS_ADDR_W-1:0] cmd_addr;
    logic [WORD_W-1:0]     cmd_word;
    logic                  cpl_valid;
    logic                  cpl_write;
    logic                  cpl_err;
    logic [WORD_W-1:0]     cpl_data;

    cmdreg_regs #(
        .REG_ADDR_W (REG_ADDR_W),
        .BUS_ADDR_W (BUS_ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .cpl_valid (cpl_valid),
        .cpl_write (cpl_write),
        .cpl_err   (cpl_err),
        .cpl_data  (cpl_data),
        .launch    (launch),
        .cmd_read  (cmd_read),
        .cmd_size  (cmd_size),
        .cmd_addr  (cmd_addr),
        .cmd_word  (cmd_word)
    );

    cmdreg_engine #(
        .BUS_ADDR_W (BUS_ADDR_W)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .launch        (launch),
        .cmd_read      (cmd_read),
        .cmd_size      (cmd_size),
        .cmd_addr      (cmd_addr),
        .cmd_word      (cmd_word),
        .busy          (busy),
        .bus_req_valid (bus_req_valid),
        .bus_req_ready (bus_req_ready),
        .bus_req_write (bus_req_write),
        .bus_req_addr  (bus_req_addr),
        .bus_req_size  (bus_req_size),
        .bus_req_wdata (bus_req_wdata),
        .bus_rsp_valid (bus_rsp_valid),
        .bus_rsp_rdata (bus_rsp_rdata),
        .bus_rsp_err   (bus_rsp_err),
        .cpl_valid     (cpl_valid),
        .cpl_write     (cpl_write),
        .cpl_err       (cpl_err),
        .cpl_data      (cpl_data)
    );

    // R11: no request while in reset
    a_r11_no_req_in_reset: assert property (@(posedge clk)
        !rst_n |=> !bus_req_valid);
endmodule

// File: tb/cmdreg_bridge_bench.sv
module cmdreg_bridge_bench;
    localparam logic [63:0] DONE = 64'h1 << 11;
    localparam logic [63:0] ONES_FIELD = 64'hFFFF_FFFF << 26;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en, reg_rd_en;
    logic [3:0]  reg_addr;
    logic [63:0] reg_wdata, reg_rdata;
    logic        bus_req_valid, bus_req_ready, bus_req_write;
    logic [31:0] bus_req_addr;
    logic [3:0]  bus_req_size;
    logic [7:0]  bus_req_wdata;
    logic        bus_rsp_valid, bus_rsp_err;
    logic [7:0]  bus_rsp_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    int          stall_mode = 0;
    logic        hold_ready = 1'b0;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int          n_beats = 0;
    logic [31:0] log_addr [0:15];
    logic [7:0]  log_wd   [0:15];
    logic        log_wr   [0:15];
    logic [3:0]  log_sz   [0:15];

    always #5 clk = ~clk;

    cmdreg_bridge u_cmdreg_bridge (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_size(bus_req_size), .bus_req_wdata(bus_req_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
        .bus_rsp_err(bus_rsp_err)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a, input int n);
        logic [31:0] w = '0;
        for (int i = 0; i < n; i++)
            w = w | ({24'b0, mem_byte(a + 32'(i))} << (24 - 8 * i));
        return w;
    endfunction

    // bus device model
    initial begin
        int  cyc = 0;
        logic pend = 1'b0;
        logic [7:0] pend_byte = '0;
        logic pend_err = 1'b0;
        bus_req_ready = 1'b0;
        bus_rsp_valid = 1'b0;
        bus_rsp_rdata = '0;
        bus_rsp_err   = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (pend) begin
                bus_rsp_valid = 1'b1;
                bus_rsp_rdata = pend_byte;
                bus_rsp_err   = pend_err;
                pend = 1'b0;
            end else begin
                bus_rsp_valid = 1'b0;
                bus_rsp_rdata = '0;
                bus_rsp_err   = 1'b0;
            end
            bus_req_ready = !hold_ready && (stall_mode == 0 || (cyc % (stall_mode + 1)) == 0);
            #4;
            if (rst_n && bus_req_valid && bus_req_ready) begin
                if (n_beats < 16) begin
                    log_addr[n_beats] = bus_req_addr;
                    log_wd[n_beats]   = bus_req_wdata;
                    log_wr[n_beats]   = bus_req_write;
                    log_sz[n_beats]   = bus_req_size;
                end
                n_beats++;
                pend      = 1'b1;
                pend_byte = mem_byte(bus_req_addr);
                pend_err  = err_en && (bus_req_addr == err_addr);
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        #4 v = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic wait_status(output logic [63:0] v);
        v = '0;
        for (int k = 0; k < 300; k++) begin
            reg_rd(4'd2, v);
            if (v != '0) break;
        end
    endtask

    function automatic logic [63:0] ctl_word(input logic rd, input logic [3:0] sz, input logic [31:0] a);
        return ({63'b0, rd} << 48) | ({60'b0, sz} << 56) | {32'b0, a};
    endfunction

    task automatic run_cmd(input logic rd, input logic [3:0] sz, input logic [31:0] a,
                           input logic [31:0] w, output logic [63:0] st);
        if (!rd) reg_wr(4'd3, {w, 32'hC0DE_F00D});
        n_beats = 0;
        reg_wr(4'd0, ctl_word(rd, sz, a));
        wait_status(st);
    endtask

    task automatic check_beats(input string req, input logic rd, input int sz,
                               input logic [31:0] a, input logic [31:0] w);
        logic ok = 1'b1;
        for (int i = 0; i < sz; i++) begin
            if (log_addr[i] !== a + 32'(i)) ok = 1'b0;
            if (log_wr[i] !== !rd) ok = 1'b0;
            if (log_sz[i] !== 4'(sz)) ok = 1'b0;
            if (!rd && log_wd[i] !== 8'((w >> (24 - 8 * i)) & 32'hFF)) ok = 1'b0;
        end
        check(req, {63'b0, ok}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [31:0] addrs [0:1];
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0; reg_wdata = '0;
        addrs[0] = 32'h0000_10FE;
        addrs[1] = 32'hFFFF_FFFE;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        for (int s = 0; s < 4; s++) begin
            reg_rd(4'(s), v);
            check("R11 slot after reset", v, 64'd0);
        end
        check("R11 no request after reset", {63'b0, bus_req_valid}, 64'd0);

        // R2 data slot
        reg_wr(4'd3, 64'h1122_3344_5566_7788);
        reg_rd(4'd3, v);
        check("R2 data readback", v, 64'h1122_3344_0000_0000);
        // R1 modulo decode: offset 15 is the data slot
        reg_rd(4'hF, v);
        check("R1 offset 15 aliases data", v, 64'h1122_3344_0000_0000);
        // R1 reset slot write has no effect
        n_beats = 0;
        reg_wr(4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        repeat (6) @(negedge clk);
        reg_rd(4'd3, v);
        check("R1 reset write keeps data", v, 64'h1122_3344_0000_0000);
        reg_rd(4'd2, v);
        check("R1 reset write no status", v, 64'd0);
        check("R1 reset write no beats", 64'(n_beats), 64'd0);
        reg_rd(4'd0, v);
        check("R1 command slot reads zero", v, 64'd0);
        reg_rd(4'd1, v);
        check("R1 reset slot reads zero", v, 64'd0);

        // R3 R4 R5 sweep
        for (int sm = 0; sm < 3; sm++) begin
            stall_mode = sm;
            for (int rd = 0; rd < 2; rd++) begin
                for (int sz = 1; sz <= 4; sz++) begin
                    for (int ai = 0; ai < 2; ai++) begin
                        logic [31:0] w = 32'hA1B2_C3D4 ^ 32'(sz * 32'h0101_0101 + ai);
                        run_cmd(rd[0], 4'(sz), addrs[ai], w, v);
                        if (rd == 0)
                            check("R4 write status", v, DONE);
                        else
                            check("R5 read status", v,
                                  DONE | ({32'b0, exp_word(addrs[ai], sz)} << 26));
                        check("R3 beat count", 64'(n_beats), 64'(sz));
                        check_beats(rd == 0 ? "R4 write beats" : "R3 read beats",
                                    rd[0], sz, addrs[ai], w);
                    end
                end
            end
        end
        stall_mode = 0;

        // R1 offset 4 launches, offset 10 reads status
        reg_wr(4'd3, 64'h5566_7788_0000_0000);
        n_beats = 0;
        reg_wr(4'd4, ctl_word(1'b0, 4'd2, 32'h0000_0200));
        repeat (12) @(negedge clk);
        reg_rd(4'hA, v);
        check("R1 offset 4 command offset 10 status", v, DONE);
        check("R1 aliased command beats", 64'(n_beats), 64'd2);

        // R7 status write ignored and read clears
        n_beats = 0;
        reg_wr(4'd0, ctl_word(1'b1, 4'd4, 32'h0000_3000));
        repeat (15) @(negedge clk);
        reg_wr(4'd2, 64'd0);
        reg_rd(4'd2, v);
        check("R7 status survives write", v, DONE | ({32'b0, exp_word(32'h3000, 4)} << 26));
        reg_rd(4'd2, v);
        check("R7 status cleared by read", v, 64'd0);
        reg_wr(4'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_rd(4'd2, v);
        check("R7 status write does not set", v, 64'd0);

        // R6 read error on beat 2
        err_en = 1'b1; err_addr = 32'h0000_4002;
        run_cmd(1'b1, 4'd4, 32'h0000_4000, 32'h0, v);
        check("R6 read error status", v, DONE | ONES_FIELD);
        check("R6 read error beat count", 64'(n_beats), 64'd3);
        err_addr = 32'h0000_5000;
        run_cmd(1'b0, 4'd3, 32'h0000_5000, 32'h1234_5678, v);
        check("R6 write error status", v, DONE);
        check("R6 write error beat count", 64'(n_beats), 64'd1);
        err_en = 1'b0;

        // R9 illegal byte counts
        for (int bi = 0; bi < 4; bi++) begin
            logic [3:0] bsz = (bi == 0) ? 4'd0 : (bi == 1) ? 4'd5 : (bi == 2) ? 4'd8 : 4'd15;
            for (int rd = 0; rd < 2; rd++) begin
                run_cmd(rd[0], bsz, 32'h0000_6000, 32'hAAAA_5555, v);
                check(rd == 1 ? "R9 illegal size read status" : "R9 illegal size write status",
                      v, rd == 1 ? (DONE | ONES_FIELD) : DONE);
                check("R9 illegal size no beats", 64'(n_beats), 64'd0);
            end
        end

        // R8 busy: second command ignored, status reads zero
        hold_ready = 1'b1;
        reg_wr(4'd3, 64'hBEEF_0102_0000_0000);
        n_beats = 0;
        reg_wr(4'd0, ctl_word(1'b0, 4'd2, 32'h0000_7000));
        reg_wr(4'd0, ctl_word(1'b1, 4'd4, 32'h0000_8000));
        reg_rd(4'd2, v);
        check("R8 status zero while busy", v, 64'd0);
        check("R10 held request visible", {63'b0, bus_req_valid}, 64'd1);
        check("R10 held request address", {32'b0, bus_req_addr}, 64'h7000);
        hold_ready = 1'b0;
        wait_status(v);
        check("R8 first command completes", v, DONE);
        check("R8 only first command beats", 64'(n_beats), 64'd2);
        check_beats("R8 first command beat content", 1'b0, 2, 32'h0000_7000, 32'hBEEF_0102);
        repeat (20) @(negedge clk);
        check("R8 ignored command never runs", 64'(n_beats), 64'd2);
        reg_rd(4'd2, v);
        check("R8 no late completion", v, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule